// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output macrocell of a sum-of-products programmable logic device. It receives eight product terms from the AND array, together with a shared clock pin and a shared active-low output-enable pin. It turns them into a pad value, a tri-state enable and a feedback line that returns to the array. Two global mode bits, shared by every cell, select one of three architectures: registered, complex or simple. Two bits local to the cell choose the polarity and the I/O role.

The cell's position in the device is fixed by a parameter: inner, centre, outer-with-clock or outer-with-OE. The position decides which feedback source the cell offers in complex and simple modes. The D register is cleared at power-up. A synchronous test preload can force any state into it, so that a state machine built from these cells can be driven into states it would not otherwise reach.

Top module: `sop_macrocell`

## Requirements
- R1: Mode encoding on `{syn_i, ac0_i}`: 2'b01 is registered, 2'b11 is complex and 2'b10 is simple. `bad_mode_o` is 1 only for 2'b00.
- R2: In registered mode with `ac1_i`=0, the register captures the OR of all eight terms on the rising clock edge. After that edge, `pad_o` equals the sum when `xor_i`=1 and the inverted sum when `xor_i`=0. `pad_o` does not change between edges.
- R3: A registered cell (registered mode, `ac1_i`=0) has `pad_oe_o` = NOT `oe_ni`.
- R4: While `rst_ni` is low, the register is 0 and a registered cell drives `pad_o`=1 for either value of `xor_i`.
- R5: If `preload_en_i`=1 at a rising edge, the register loads `preload_val_i` and ignores the terms. After that edge, a registered cell drives `pad_o` = NOT `preload_val_i`.
- R6: In registered mode with `ac1_i`=1, and in complex mode, the sum is the OR of terms 7..1. `pad_o` is the sum when `xor_i`=1 and its inverse when `xor_i`=0. `pad_oe_o` equals term 0, and term 0 has no effect on `pad_o`.
- R7: In complex mode, `ac1_i` has no effect on `pad_o`, `pad_oe_o` or `fb_o`.
- R8: In simple mode with `ac1_i`=0, `pad_o` is the OR of all eight terms, with polarity set by `xor_i`, and `pad_oe_o`=1. With `ac1_i`=1, a non-centre cell has `pad_oe_o`=0.
- R9: In simple mode, `fb_o` equals `nbr_pin_i` for a non-centre cell. A centre cell keeps `pad_oe_o`=1 whatever `ac1_i` is, and holds `fb_o`=0.
- R10: In complex mode, `fb_o` is `clk_i` for the outer-with-clock cell and `oe_ni` for the outer-with-OE cell. For every other cell it is `pin_i`.
- R11: In registered mode, a registered cell feeds back the inverted register output, which is the value on `pad_o`, whatever `pin_i` is. A combinational cell feeds back `pin_i`.
- R12: The encoding 2'b00 behaves exactly like simple mode for `pad_o`, `pad_oe_o` and `fb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock pin; also a data source for the outer-with-clock cell in complex mode |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| oe_ni | input | 1 | Shared active-low output-enable pin |
| syn_i | input | 1 | Global mode bit, high for complex or simple |
| ac0_i | input | 1 | Global mode bit, high for registered or complex |
| ac1_i | input | 1 | Per-cell I/O role bit |
| xor_i | input | 1 | Per-cell polarity, 1 for active-high |
| pterm_i | input | N_TERMS | Product terms from the AND array |
| pin_i | input | 1 | Value read back from this cell's pad |
| nbr_pin_i | input | 1 | Value read back from the adjacent cell's pad |
| preload_en_i | input | 1 | Test preload strobe, sampled on the clock edge |
| preload_val_i | input | 1 | Value forced into the register by a preload |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe_o | output | 1 | Tri-state enable for the pad driver |
| fb_o | output | 1 | Feedback line into the AND array |
| bad_mode_o | output | 1 | High on the unused mode encoding |

## Verification
The combinational paths have no register in them: pad value, enable, feedback and mode flag all follow their inputs within the same cycle. The bench changes inputs on the falling edge and samples one time unit later, while the clock is still low. The register path has one stage. Its result, from either the terms or a preload, is due after the first rising edge that follows the stimulus. The bench samples it two units past that edge, and it also samples just before the edge to confirm that the pad has not yet moved. Reset is asynchronous, so its effect is checked while reset is still held. The clock-as-feedback cell is sampled once in each clock phase.

// File: rtl/sop_macrocell_pkg.sv
package sop_macrocell_pkg;
  typedef enum logic [1:0] {
    MODE_REG    = 2'd0,
    MODE_CPLX   = 2'd1,
    MODE_SIMPLE = 2'd2
  } mc_mode_e;

  typedef enum logic [1:0] {
    CELL_INNER    = 2'd0,
    CELL_CENTRE   = 2'd1,
    CELL_EDGE_CLK = 2'd2,
    CELL_EDGE_OE  = 2'd3
  } cell_kind_e;
endpackage

// File: rtl/mc_mode_dec.sv
module mc_mode_dec
  import sop_macrocell_pkg::*;
#(
  parameter cell_kind_e CELL_KIND = CELL_INNER
) (
  input  logic     syn_i,
  input  logic     ac0_i,
  input  logic     ac1_i,
  output mc_mode_e mode_o,
  output logic     use_reg_o,
  output logic     term_oe_o,
  output logic     pin_in_o,
  output logic     bad_mode_o
);
  localparam bit IS_CENTRE = (CELL_KIND == CELL_CENTRE);

  always_comb begin
    unique case ({syn_i, ac0_i})
      2'b01:   mode_o = MODE_REG;
      2'b11:   mode_o = MODE_CPLX;
      default: mode_o = MODE_SIMPLE;  // 2'b00 falls back to simple
    endcase
  end

  assign bad_mode_o = ~syn_i & ~ac0_i;
  assign use_reg_o  = (mode_o == MODE_REG) & ~ac1_i;
  assign term_oe_o  = ((mode_o == MODE_REG) & ac1_i) | (mode_o == MODE_CPLX);
  assign pin_in_o   = (mode_o == MODE_SIMPLE) & ac1_i & ~IS_CENTRE;
endmodule

// File: rtl/mc_term_steer.sv
module mc_term_steer #(
  parameter int N_TERMS = 8,
  parameter int OE_IDX  = 0
) (
  input  logic [N_TERMS-1:0] pterm_i,
  input  logic               term_oe_i,
  input  logic               xor_i,
  output logic               comb_o,
  output logic               reg_d_o,
  output logic               oe_term_o
);
  logic [N_TERMS-1:0] mask;
  logic               sum;

  always_comb begin
    mask = '1;
    if (term_oe_i) mask[OE_IDX] = 1'b0;
  end

  assign sum       = |(pterm_i & mask);
  assign oe_term_o = pterm_i[OE_IDX];
  // pad = ~q, so the register stores the pre-inverted value
  assign reg_d_o   = sum ^ xor_i;
  assign comb_o    = ~(sum ^ xor_i);
endmodule

// File: rtl/mc_dreg.sv
module mc_dreg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           q_o <= 1'b0;
    else if (preload_en_i) q_o <= preload_val_i;
    else                   q_o <= d_i;
  end
endmodule

// File: rtl/mc_fb_sel.sv
module mc_fb_sel
  import sop_macrocell_pkg::*;
#(
  parameter cell_kind_e CELL_KIND = CELL_INNER
) (
  input  logic     clk_i,
  input  logic     oe_ni,
  input  mc_mode_e mode_i,
  input  logic     use_reg_i,
  input  logic     q_i,
  input  logic     pin_i,
  input  logic     nbr_pin_i,
  output logic     fb_o
);
  logic cplx_src;
  logic simple_src;

  generate
    if (CELL_KIND == CELL_EDGE_CLK) begin : g_edge_clk
      assign cplx_src = clk_i;
    end else if (CELL_KIND == CELL_EDGE_OE) begin : g_edge_oe
      assign cplx_src = oe_ni;
    end else begin : g_own_pin
      assign cplx_src = pin_i;
    end

    if (CELL_KIND == CELL_CENTRE) begin : g_no_fb
      assign simple_src = 1'b0;
    end else begin : g_nbr_fb
      assign simple_src = nbr_pin_i;
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MODE_REG:  fb_o = use_reg_i ? ~q_i : pin_i;
      MODE_CPLX: fb_o = cplx_src;
      default:   fb_o = simple_src;
    endcase
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_macrocell_pkg::*;
#(
  parameter int         N_TERMS   = 8,
  parameter cell_kind_e CELL_KIND = CELL_INNER
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               oe_ni,
  input  logic               syn_i,
  input  logic               ac0_i,
  input  logic               ac1_i,
  input  logic               xor_i,
  input  logic [N_TERMS-1:0] pterm_i,
  input  logic               pin_i,
  input  logic               nbr_pin_i,
  input  logic               preload_en_i,
  input  logic               preload_val_i,
  output logic               pad_o,
  output logic               pad_oe_o,
  output logic               fb_o,
  output logic               bad_mode_o
);
  localparam int OE_IDX = 0;

  mc_mode_e mode;
  logic     use_reg, term_oe, pin_in;
  logic     comb_val, reg_d, oe_term, q;

  mc_mode_dec #(.CELL_KIND(CELL_KIND)) u_dec (
    .syn_i      (syn_i),
    .ac0_i      (ac0_i),
    .ac1_i      (ac1_i),
    .mode_o     (mode),
    .use_reg_o  (use_reg),
    .term_oe_o  (term_oe),
    .pin_in_o   (pin_in),
    .bad_mode_o (bad_mode_o)
  );

  mc_term_steer #(.N_TERMS(N_TERMS), .OE_IDX(OE_IDX)) u_steer (
    .pterm_i   (pterm_i),
    .term_oe_i (term_oe),
    .xor_i     (xor_i),
    .comb_o    (comb_val),
    .reg_d_o   (reg_d),
    .oe_term_o (oe_term)
  );

  mc_dreg u_reg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .d_i           (reg_d),
    .preload_en_i  (preload_en_i),
    .preload_val_i (preload_val_i),
    .q_o           (q)
  );

  mc_fb_sel #(.CELL_KIND(CELL_KIND)) u_fb (
    .clk_i     (clk_i),
    .oe_ni     (oe_ni),
    .mode_i    (mode),
    .use_reg_i (use_reg),
    .q_i       (q),
    .pin_i     (pin_i),
    .nbr_pin_i (nbr_pin_i),
    .fb_o      (fb_o)
  );

  // inverting driver: cleared register shows as a high pad
  assign pad_o = use_reg ? ~q : comb_val;

  always_comb begin
    if (use_reg)      pad_oe_o = ~oe_ni;
    else if (term_oe) pad_oe_o = oe_term;
    else              pad_oe_o = ~pin_in;
  end
endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk
  import sop_macrocell_pkg::*;
#(
  parameter int         N_TERMS   = 8,
  parameter cell_kind_e CELL_KIND = CELL_INNER
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               oe_ni,
  input logic               syn_i,
  input logic               ac0_i,
  input logic               ac1_i,
  input logic               xor_i,
  input logic [N_TERMS-1:0] pterm_i,
  input logic               preload_en_i,
  input logic               preload_val_i,
  input logic               pad_o,
  input logic               pad_oe_o
);
  logic in_reg, seven_term, simple_like;
  assign in_reg      = ~syn_i & ac0_i & ~ac1_i;
  assign seven_term  = (~syn_i & ac0_i & ac1_i) | (syn_i & ac0_i);
  assign simple_like = ~ac0_i;

  // R2
  a_r2_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_reg && $past(in_reg) && $past(rst_ni) && !$past(preload_en_i))
      |-> pad_o == ~((|$past(pterm_i)) ^ $past(xor_i)));

  // R5
  a_r5_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_reg && $past(rst_ni) && $past(preload_en_i))
      |-> pad_o == ~$past(preload_val_i));

  // R3
  a_r3_shared_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reg |-> pad_oe_o == ~oe_ni);

  // R6
  a_r6_term_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seven_term |-> pad_oe_o == pterm_i[0]);

  // R8, R9
  a_r8_simple_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (simple_like && !ac1_i) |-> pad_oe_o);

  a_r9_centre_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (simple_like && CELL_KIND == CELL_CENTRE) |-> pad_oe_o);

  // R4
  always_comb begin
    if (!rst_ni && in_reg) a_r4_reset_high: assert (pad_o);
  end
endmodule

bind sop_macrocell sop_macrocell_chk #(.N_TERMS(N_TERMS), .CELL_KIND(CELL_KIND)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .oe_ni         (oe_ni),
  .syn_i         (syn_i),
  .ac0_i         (ac0_i),
  .ac1_i         (ac1_i),
  .xor_i         (xor_i),
  .pterm_i       (pterm_i),
  .preload_en_i  (preload_en_i),
  .preload_val_i (preload_val_i),
  .pad_o         (pad_o),
  .pad_oe_o      (pad_oe_o)
);

// File: tb/sop_macrocell_bench.sv
module sop_macrocell_bench;
  import sop_macrocell_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_TERMS    = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic oe_ni = 1'b0;
  logic syn_i = 1'b0, ac0_i = 1'b1, ac1_i = 1'b0, xor_i = 1'b0;
  logic [N_TERMS-1:0] pterm_i = '0;
  logic pin_i = 1'b0, nbr_pin_i = 1'b0;
  logic preload_en_i = 1'b0, preload_val_i = 1'b0;

  logic pad_i_o, oe_i_o, fb_i_o, bad_i_o;
  logic pad_c_o, oe_c_o, fb_c_o, bad_c_o;
  logic pad_k_o, oe_k_o, fb_k_o, bad_k_o;
  logic pad_e_o, oe_e_o, fb_e_o, bad_e_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sop_macrocell #(.N_TERMS(N_TERMS), .CELL_KIND(CELL_INNER)) u_sop_macrocell (
    .clk_i, .rst_ni, .oe_ni, .syn_i, .ac0_i, .ac1_i, .xor_i, .pterm_i, .pin_i,
    .nbr_pin_i, .preload_en_i, .preload_val_i,
    .pad_o(pad_i_o), .pad_oe_o(oe_i_o), .fb_o(fb_i_o), .bad_mode_o(bad_i_o));

  sop_macrocell #(.N_TERMS(N_TERMS), .CELL_KIND(CELL_CENTRE)) u_sop_macrocell_centre (
    .clk_i, .rst_ni, .oe_ni, .syn_i, .ac0_i, .ac1_i, .xor_i, .pterm_i, .pin_i,
    .nbr_pin_i, .preload_en_i, .preload_val_i,
    .pad_o(pad_c_o), .pad_oe_o(oe_c_o), .fb_o(fb_c_o), .bad_mode_o(bad_c_o));

  sop_macrocell #(.N_TERMS(N_TERMS), .CELL_KIND(CELL_EDGE_CLK)) u_sop_macrocell_eclk (
    .clk_i, .rst_ni, .oe_ni, .syn_i, .ac0_i, .ac1_i, .xor_i, .pterm_i, .pin_i,
    .nbr_pin_i, .preload_en_i, .preload_val_i,
    .pad_o(pad_k_o), .pad_oe_o(oe_k_o), .fb_o(fb_k_o), .bad_mode_o(bad_k_o));

  sop_macrocell #(.N_TERMS(N_TERMS), .CELL_KIND(CELL_EDGE_OE)) u_sop_macrocell_eoe (
    .clk_i, .rst_ni, .oe_ni, .syn_i, .ac0_i, .ac1_i, .xor_i, .pterm_i, .pin_i,
    .nbr_pin_i, .preload_en_i, .preload_val_i,
    .pad_o(pad_e_o), .pad_oe_o(oe_e_o), .fb_o(fb_e_o), .bad_mode_o(bad_e_o));

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic s, input logic a0, input logic a1, input logic x);
    syn_i = s; ac0_i = a0; ac1_i = a1; xor_i = x;
  endtask

  // drive at falling edge, sample one unit later (clock low)
  task automatic comb_step();
    #1;
  endtask

  // wait for next rising edge, sample two units after it
  task automatic reg_step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic t_reset();
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    #3;
    check("R4 reset pad high, xor=0", pad_i_o, 1'b1);
    xor_i = 1'b1;
    #1;
    check("R4 reset pad high, xor=1", pad_i_o, 1'b1);
    check("R3 reset pad_oe with oe_ni=0", oe_i_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_mode_flag();
    @(negedge clk_i);
    set_mode(1'b0, 1'b0, 1'b0, 1'b0); comb_step();
    check("R1 flag on 00", bad_i_o, 1'b1);
    set_mode(1'b0, 1'b1, 1'b0, 1'b0); comb_step();
    check("R1 flag on 01", bad_i_o, 1'b0);
    set_mode(1'b1, 1'b0, 1'b0, 1'b0); comb_step();
    check("R1 flag on 10", bad_i_o, 1'b0);
    set_mode(1'b1, 1'b1, 1'b0, 1'b0); comb_step();
    check("R1 flag on 11", bad_i_o, 1'b0);
  endtask

  task automatic t_registered();
    @(negedge clk_i);
    set_mode(1'b0, 1'b1, 1'b0, 1'b1);
    pterm_i = 8'h80; oe_ni = 1'b0;
    reg_step();
    check("R2 active-high sum=1", pad_i_o, 1'b1);
    @(negedge clk_i);
    pterm_i = 8'h00; comb_step();
    check("R2 holds before edge", pad_i_o, 1'b1);
    reg_step();
    check("R2 active-high sum=0", pad_i_o, 1'b0);
    @(negedge clk_i);
    xor_i = 1'b0; pin_i = 1'b1;
    reg_step();
    check("R2 active-low sum=0", pad_i_o, 1'b1);
    check("R11 reg feedback follows register", fb_i_o, 1'b1);
    @(negedge clk_i);
    pterm_i = 8'h01; pin_i = 1'b1;
    reg_step();
    check("R2 active-low sum=1 (term0 counted)", pad_i_o, 1'b0);
    check("R11 reg feedback ignores pin", fb_i_o, 1'b0);
    @(negedge clk_i);
    oe_ni = 1'b1; comb_step();
    check("R3 oe_ni=1 disables", oe_i_o, 1'b0);
    oe_ni = 1'b0; comb_step();
    check("R3 oe_ni=0 enables", oe_i_o, 1'b1);
  endtask

  task automatic t_preload();
    @(negedge clk_i);
    set_mode(1'b0, 1'b1, 1'b0, 1'b1);
    pterm_i = 8'hFF; preload_en_i = 1'b1; preload_val_i = 1'b1;
    reg_step();
    check("R5 preload 1 overrides terms", pad_i_o, 1'b0);
    @(negedge clk_i);
    pterm_i = 8'h00; preload_val_i = 1'b0;
    reg_step();
    check("R5 preload 0 overrides terms", pad_i_o, 1'b1);
    @(negedge clk_i);
    preload_en_i = 1'b0;
  endtask

  task automatic t_reg_comb();
    @(negedge clk_i);
    set_mode(1'b0, 1'b1, 1'b1, 1'b1);
    pterm_i = 8'h03; comb_step();
    check("R6 reg-mode comb pad", pad_i_o, 1'b1);
    check("R6 reg-mode comb oe from term0", oe_i_o, 1'b1);
    pterm_i = 8'h01; comb_step();
    check("R6 term0 not in sum", pad_i_o, 1'b0);
    pterm_i = 8'h02; comb_step();
    check("R6 term0 low disables", oe_i_o, 1'b0);
    xor_i = 1'b0; pterm_i = 8'h03; comb_step();
    check("R6 active-low comb", pad_i_o, 1'b0);
    pin_i = 1'b1; comb_step();
    check("R11 comb feedback pin=1", fb_i_o, 1'b1);
    pin_i = 1'b0; comb_step();
    check("R11 comb feedback pin=0", fb_i_o, 1'b0);
  endtask

  task automatic t_complex();
    @(negedge clk_i);
    set_mode(1'b1, 1'b1, 1'b0, 1'b1);
    pterm_i = 8'h05; pin_i = 1'b1; oe_ni = 1'b1; comb_step();
    check("R6 complex pad", pad_i_o, 1'b1);
    check("R6 complex oe", oe_i_o, 1'b1);
    check("R10 inner fb = pin", fb_i_o, 1'b1);
    ac1_i = 1'b1; comb_step();
    check("R7 ac1 ignored pad", pad_i_o, 1'b1);
    check("R7 ac1 ignored oe", oe_i_o, 1'b1);
    check("R7 ac1 ignored fb", fb_i_o, 1'b1);
    check("R10 edge-oe fb = oe_ni=1", fb_e_o, 1'b1);
    oe_ni = 1'b0; comb_step();
    check("R10 edge-oe fb = oe_ni=0", fb_e_o, 1'b0);
    check("R10 edge-clk fb, clock low", fb_k_o, 1'b0);
    @(posedge clk_i); #1;
    check("R10 edge-clk fb, clock high", fb_k_o, 1'b1);
  endtask

  task automatic t_simple();
    @(negedge clk_i);
    set_mode(1'b1, 1'b0, 1'b0, 1'b1);
    pterm_i = 8'h01; comb_step();
    check("R8 simple eight-term pad", pad_i_o, 1'b1);
    check("R8 simple always enabled", oe_i_o, 1'b1);
    xor_i = 1'b0; comb_step();
    check("R8 simple active-low", pad_i_o, 1'b0);
    ac1_i = 1'b1; comb_step();
    check("R8 input cell driver off", oe_i_o, 1'b0);
    check("R9 centre still drives", oe_c_o, 1'b1);
    nbr_pin_i = 1'b1; pin_i = 1'b0; comb_step();
    check("R9 fb from neighbour", fb_i_o, 1'b1);
    check("R9 centre no feedback", fb_c_o, 1'b0);
  endtask

  task automatic t_illegal();
    @(negedge clk_i);
    set_mode(1'b0, 1'b0, 1'b1, 1'b1);
    nbr_pin_i = 1'b0; pin_i = 1'b1; pterm_i = 8'h01; comb_step();
    check("R12 illegal acts as input cell", oe_i_o, 1'b0);
    check("R12 illegal fb from neighbour", fb_i_o, 1'b0);
    ac1_i = 1'b0; comb_step();
    check("R12 illegal output enabled", oe_i_o, 1'b1);
    check("R12 illegal eight-term pad", pad_i_o, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_mode_flag();
    t_registered();
    t_preload();
    t_reg_comb();
    t_complex();
    t_simple();
    t_illegal();
    @(negedge clk_i);
    finish_run();
  end
endmodule